// File: doc/BRIEF.md
# Character FIFO with Packed Status

This block is a synchronous first-in first-out buffer for 7-bit characters. It sits between a serial line engine and a bus register file. One instance is placed in each direction. In the receive direction the line engine pushes characters and the bus side pops them. In the transmit direction the bus side pushes and the line engine pops.

A parameter gives the log2 of the depth. It is clamped into the range 2 to 10 before use. A second parameter picks the receive or the transmit role. The role changes only the meaning of the two low status bits. Software then sees an interrupt-style condition that suits its direction: data waiting, or room to write.

Every pop places the oldest character into a read-data register on the following clock. A 16-bit status word combines the effective log2 depth, the current fill level and the two role flags. A sticky error flag records any push onto a full buffer and any pop from an empty buffer. A synchronous reset empties the buffer and clears the error flag.

Top module: `char_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the buffer is emptied. After that edge, `not_empty` is 0, the fill field is 0, `err` is 0 and `rd_data` is 0.
- R2: Characters leave in the order in which they were accepted. A successful pop loads `rd_data` at the same rising edge, so the value is visible in the cycle after the request. `rd_data` then holds until the next successful pop.
- R3: `not_empty` is 1 exactly when the buffer holds at least one character.
- R4: `status[15:12]` holds the effective log2 depth. This is `LG_DEPTH` clamped to the range 2..10, so a request of 1 gives 2 and a depth of 4 entries.
- R5: `status[11:2]` holds the low 10 bits of the number of characters currently stored.
- R6: With `IS_RX` = 1, `status[0]` is 1 when the fill is above zero. `status[1]` is 1 when the fill is strictly greater than half the depth.
- R7: With `IS_RX` = 0, `status[0]` is 1 when the fill is below the depth. `status[1]` is 1 when the fill is strictly below half the depth.
- R8: A push on a full buffer with no pop in the same cycle is dropped. It leaves the contents unchanged and sets `err`.
- R9: A pop on an empty buffer sets `err` and leaves `rd_data` unchanged.
- R10: Once set, `err` stays at 1 until a reset.
- R11: When push and pop coincide on a non-empty buffer, including a full one, both take effect and the fill level is unchanged.
- R12: When push and pop coincide on an empty buffer, the character is stored, the pop fails and `err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W (7) | Character to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W (7) | Registered character from the last successful pop |
| not_empty | output | 1 | At least one character is stored |
| status | output | 16 | {log2 depth[3:0], fill[9:0], role flags[1:0]} |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The hardest cases to reach are a push and a pop in the same cycle while the buffer is exactly full, and the same pair on an empty buffer. Each of these needs a precise run of earlier pushes before the coincident cycle. The stimulus fills the buffer with an exact count before holding both requests high. It also resets just before the empty-buffer case, so the empty and full edges are met on purpose rather than by chance. A shallow, clamped instance is driven alongside the default ones. Random traffic therefore hits its full boundary often, and the clamp is checked under load.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  localparam int LG_MIN = 2;
  localparam int LG_MAX = 10;

  function automatic int clamp_lg(input int req);
    if (req < LG_MIN) return LG_MIN;
    if (req > LG_MAX) return LG_MAX;
    return req;
  endfunction

  function automatic logic [15:0] pack_status(input logic [3:0] lg,
                                              input logic [10:0] fill,
                                              input logic [1:0] flags);
    return {lg, fill[9:0], flags};
  endfunction

endpackage

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [AW:0]   fill,
  output logic          err
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic push_bad, pop_bad;

  assign pop_ok   = rd_en && (fill != '0);
  assign push_ok  = wr_en && ((fill != FULL_CNT) || pop_ok);
  assign pop_bad  = rd_en && !pop_ok;
  assign push_bad = wr_en && !push_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      err    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (push_bad || pop_bad) err <= 1'b1;
    end
  end
endmodule

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int AW = 4,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/cfifo_status.sv
module cfifo_status #(
  parameter int AW    = 4,
  parameter bit IS_RX = 1'b1
) (
  input  logic [AW:0] fill,
  output logic [15:0] status
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HALF_CNT = {2'b01, {(AW-1){1'b0}}};

  logic [1:0] flags;

  generate
    if (IS_RX) begin : g_rx
      assign flags = {fill > HALF_CNT, fill != '0};
    end else begin : g_tx
      assign flags = {fill < HALF_CNT, fill < FULL_CNT};
    end
  endgenerate

  assign status = cfifo_pkg::pack_status(4'(AW), 11'(fill), flags);
endmodule

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int LG_DEPTH = 4,
  parameter bit IS_RX    = 1'b1,
  parameter int DATA_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic [15:0]       status,
  output logic              err
);
  localparam int AW    = cfifo_pkg::clamp_lg(LG_DEPTH);
  localparam int DEPTH = 1 << AW;

  logic          push_ok, pop_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;

  cfifo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill), .err(err)
  );

  cfifo_mem #(.AW(AW), .DW(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .we(push_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(pop_ok), .raddr(rd_ptr), .rdata(rd_data)
  );

  cfifo_status #(.AW(AW), .IS_RX(IS_RX)) u_stat (
    .fill(fill), .status(status)
  );

  assign not_empty = (fill != '0);
endmodule

// File: rtl/char_fifo_chk.sv
module char_fifo_chk #(
  parameter int AW = 4,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          err,
  input logic [AW:0]   fill,
  input logic          push_ok,
  input logic          pop_ok
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (fill == '0) && !err && (rd_data == '0)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !pop_ok |=> $stable(rd_data)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fill <= FULL_CNT); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && fill == FULL_CNT) |=> (fill == FULL_CNT) && err); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (rd_en && fill == '0) |=> err); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R10
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(fill)); // R11
  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && fill == '0) |=> (fill == 1) && err); // R12
endmodule

bind char_fifo char_fifo_chk #(.AW(AW), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .err(err), .fill(fill), .push_ok(push_ok), .pop_ok(pop_ok)
);

// File: tb/char_fifo_test.sv
module char_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0] wr_data = '0;

  logic [6:0]  rd_a, rd_t, rd_s;
  logic        ne_a, ne_t, ne_s, er_a, er_t, er_s;
  logic [15:0] st_a, st_t, st_s;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  char_fifo #(.LG_DEPTH(4), .IS_RX(1'b1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_a), .not_empty(ne_a), .status(st_a), .err(er_a));
  char_fifo #(.LG_DEPTH(4), .IS_RX(1'b0)) uut_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_t), .not_empty(ne_t), .status(st_t), .err(er_t));
  char_fifo #(.LG_DEPTH(1), .IS_RX(1'b1)) uut_small (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_s), .not_empty(ne_s), .status(st_s), .err(er_s));

  // behavioural reference: one queue for depth 16, one for clamped depth 4
  logic [6:0] qa[$];
  logic [6:0] qs[$];
  logic       m_err_a = 1'b0, m_err_s = 1'b0;
  logic [6:0] m_rd_a = '0, m_rd_s = '0;

  always @(posedge clk) begin
    if (rst) begin
      qa.delete(); qs.delete();
      m_err_a = 1'b0; m_err_s = 1'b0; m_rd_a = '0; m_rd_s = '0;
    end else begin
      bit pa, wa, ps, ws;
      pa = rd_en && (qa.size() > 0);
      wa = wr_en && (qa.size() < 16 || pa);
      ps = rd_en && (qs.size() > 0);
      ws = wr_en && (qs.size() < 4 || ps);
      if ((rd_en && !pa) || (wr_en && !wa)) m_err_a = 1'b1;
      if ((rd_en && !ps) || (wr_en && !ws)) m_err_s = 1'b1;
      if (pa) m_rd_a = qa.pop_front();
      if (wa) qa.push_back(wr_data);
      if (ps) m_rd_s = qs.pop_front();
      if (ws) qs.push_back(wr_data);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int na, ns;
    na = qa.size(); ns = qs.size();
    chk("R2 rd_data rx", rd_a, m_rd_a);
    chk("R2 rd_data tx", rd_t, m_rd_a);
    chk("R2 rd_data small", rd_s, m_rd_s);
    chk("R3 not_empty", ne_a, na > 0);
    chk("R3 not_empty small", ne_s, ns > 0);
    chk("R4 lg field", st_a[15:12], 4);
    chk("R4 lg field clamped", st_s[15:12], 2);
    chk("R5 fill field", st_a[11:2], na);
    chk("R5 fill field tx", st_t[11:2], na);
    chk("R5 fill field small", st_s[11:2], ns);
    chk("R6 rx flags", st_a[1:0], {na > 8, na > 0});
    chk("R6 rx flags small", st_s[1:0], {ns > 2, ns > 0});
    chk("R7 tx flags", st_t[1:0], {na < 8, na < 16});
    chk("R8 R9 R10 err", er_a, m_err_a);
    chk("R8 R9 R10 err tx", er_t, m_err_a);
    chk("R8 R9 R10 err small", er_s, m_err_s);
  end

  task automatic step(input logic w, input logic r, input logic [6:0] d);
    @(negedge clk);
    #1;
    wr_en = w; rd_en = r; wr_data = d;
  endtask

  task automatic do_reset();
    step(1'b0, 1'b0, '0);
    rst = 1'b1;
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    phase = "R1";
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
    // R2: order and registered read
    phase = "R2";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 7'(8'h41 + i));
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);
    // R9: pop on empty
    phase = "R9";
    step(1'b0, 1'b1, '0);
    // R10: err stays set
    phase = "R10";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 7'(i + 3));
    step(1'b0, 1'b0, '0);
    phase = "R1";
    do_reset();
    // R8: overfill
    phase = "R8";
    for (int i = 0; i < 19; i++) step(1'b1, 1'b0, 7'(i * 5));
    step(1'b0, 1'b0, '0);
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, '0);
    phase = "R1";
    do_reset();
    // R11: simultaneous at full and mid level
    phase = "R11";
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 7'(i + 16));
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 7'(i + 100));
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, '0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 7'(i + 64));
    phase = "R1";
    do_reset();
    // R12: simultaneous on empty
    phase = "R12";
    step(1'b1, 1'b1, 7'h2a);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    // random mixed traffic with occasional reset
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel == 0) begin
        phase = "R1"; do_reset(); phase = "R2";
      end else begin
        step(sel < 55, (sel % 3) != 0, 7'($urandom));
      end
    end
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    finish_run();
  end
endmodule